// File: doc/BRIEF.md
# Stored-Pattern Step Sequencer with Response Compare

This block behaves like a very small stored-pattern tester. It walks an ordered list of steps and applies them to a group of terminals, one step per clock. Each step carries one event for every terminal. An event is a drive, a measure or nothing, and its value is 0, 1, Z or don't-care. Drive values stay on the terminals until a later drive replaces them. A measure compares the sampled terminal input against its expected value for that one step only.

Steps come from one of two sources, chosen when a run starts. The first is a built-in program computed from the step index. It pulses one terminal low-high-low and checks a second terminal after each pulse, repeating this for a parameterised number of loops. It then checks a completion terminal. The second source is a loader port that presents one step per cycle. A run is accepted only while the test configuration is enabled. The block reports completion, an illegal-step error and a sticky mismatch flag. The mismatch flag comes with the index of the first step that failed.

Top module: `pattern_step_seq`

## Requirements
- R1: After reset every terminal is released (`term_oe` all 0, `term_drv` all 0), no measure is active, and `busy`, `done`, `fail` and `err` are 0.
- R2: `start` is taken only while `cfg_en` is 1 and the block is idle. While `cfg_en` is 0 during a run, no step is consumed and the terminals keep their state.
- R3: Each terminal i owns bits [4i+3:4i] of a step. Bits [4i+3:4i+2] hold the event kind: 00 none, 01 drive, 10 measure, 11 none. Bits [4i+1:4i] hold the value: 00 is 0, 01 is 1, 10 is Z, 11 is don't-care. A drive of 0 or 1 sets `term_drv[i]` to that value and sets `term_oe[i]`. A drive of Z clears both.
- R4: A driven state persists through later steps until another drive of 0, 1 or Z on the same terminal. A don't-care drive and a step with no event leave the terminal unchanged.
- R5: A measure taken at a clock edge is active only in the following cycle. In that cycle `meas_on[i]` is 1 and `term_in[i]` is compared against the expected value. A following step without a measure, or a loader gap, clears `meas_on[i]` and no compare is made.
- R6: A measure that expects don't-care or Z is masked. It sets `meas_on[i]` but not `cmp_en[i]`, and it can never raise `fail`.
- R7: A step that holds both drive and measure events sets `err`, ends the run (`busy` falls) and is not applied. In that case `done` stays 0.
- R8: `fail` latches on the first compare mismatch, one cycle after the failing step's compare cycle. `fail_step` gives that step's index, counted from 0 over the steps taken. Later mismatches change neither output until the next start.
- R9: `done` rises one cycle after the compare cycle of the last step. That last step is the built-in program's final step, or the loader step taken with `ld_last` set. `busy` is 0 from then on.
- R10: The built-in program has 4*LOOP_N+2 steps. Each loop drives terminal A1_T to 0, then 1, then 0, then measures terminal C_T expecting 0. After the loops it drives A1_T to 0 and then measures terminal B_T expecting 1.
- R11: In loader mode, a step is taken in each cycle with `ld_valid` high. A cycle with `ld_valid` low takes no step and does not advance the step index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Test configuration enabled; gates start and step consumption |
| start | input | 1 | Begin a run (pulse) |
| src_ld | input | 1 | Step source captured at start: 1 loader, 0 built-in program |
| ld_valid | input | 1 | Loader step present this cycle |
| ld_step | input | 4*NTERM | Loader step, four bits per terminal |
| ld_last | input | 1 | Loader step is the final one |
| term_in | input | NTERM | Sampled terminal responses |
| term_drv | output | NTERM | Driven terminal values |
| term_oe | output | NTERM | Terminal output enables |
| meas_on | output | NTERM | Measure event active this cycle (masked or not) |
| cmp_en | output | NTERM | Unmasked compare active this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run completed |
| err | output | 1 | Run stopped on a mixed drive/measure step |
| fail | output | 1 | Sticky mismatch flag |
| fail_step | output | IDXW | Index of first mismatching step |

## Verification
The bench builds the block with NTERM=4, LOOP_N=4 and IDXW=8. The built-in program then shrinks to 18 steps, so a short run covers the whole sequence: the loop boundaries, the trailing drive and the closing flag measure. With four terminals, a single loader run can hold a persistent drive, a Z release and a masked and an unmasked measure side by side. It can also put a mismatch on a terminal that the built-in program never uses. The narrow index still reaches the first-failure index in both the loader and the built-in program runs.

// File: rtl/pss_pkg.sv
// Shared encodings for the pattern step sequencer.
// Assumes a four-bit event per terminal: kind in the upper pair, value in the lower.
package pss_pkg;
    localparam int EVT_W = 4;

    localparam logic [1:0] OP_NONE = 2'b00;
    localparam logic [1:0] OP_DRV  = 2'b01;
    localparam logic [1:0] OP_MEAS = 2'b10;

    localparam logic [1:0] VAL_0 = 2'b00;
    localparam logic [1:0] VAL_1 = 2'b01;
    localparam logic [1:0] VAL_Z = 2'b10;
    localparam logic [1:0] VAL_X = 2'b11;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] val;
    } evt_t;
endpackage

// File: rtl/pss_prog.sv
// Built-in self-test program, computed from the step index (no stored table).
// Loop body of four steps repeated LOOP_N times, then a drive and a flag check.
// Assumes IDXW is wide enough to hold 4*LOOP_N+2 and the terminal indices are distinct.
module pss_prog
    import pss_pkg::*;
#(
    parameter int NTERM  = 4,
    parameter int LOOP_N = 1024,
    parameter int IDXW   = 16,
    parameter int A1_T   = 0,
    parameter int B_T    = 1,
    parameter int C_T    = 2
) (
    input  logic [IDXW-1:0]        idx,
    output logic [NTERM*EVT_W-1:0] step,
    output logic                   last
);
    localparam logic [IDXW-1:0] BODY_LEN = IDXW'(4 * LOOP_N);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(4 * LOOP_N + 1);

    // Select the event set for the current index.
    always_comb begin
        step = '0;
        if (idx < BODY_LEN) begin
            case (idx[1:0])
                2'd0:    step[A1_T*EVT_W +: EVT_W] = {OP_DRV, VAL_0};
                2'd1:    step[A1_T*EVT_W +: EVT_W] = {OP_DRV, VAL_1};
                2'd2:    step[A1_T*EVT_W +: EVT_W] = {OP_DRV, VAL_0};
                default: step[C_T*EVT_W +: EVT_W]  = {OP_MEAS, VAL_0};
            endcase
        end else if (idx == BODY_LEN) begin
            step[A1_T*EVT_W +: EVT_W] = {OP_DRV, VAL_0};
        end else begin
            step[B_T*EVT_W +: EVT_W] = {OP_MEAS, VAL_1};
        end
    end

    assign last = (idx == LAST_IDX);
endmodule

// File: rtl/pss_lane.sv
// One terminal lane: holds the driven state across steps and holds a
// one-step measure expectation, producing a mismatch for the compare cycle.
// Assumes apply is high only for a legal step; clr restarts the lane for a new run.
module pss_lane
    import pss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic apply,
    input  evt_t evt,
    input  logic pin_in,
    output logic drv,
    output logic oe,
    output logic meas_on,
    output logic cmp_en,
    output logic miss
);
    logic [1:0] exp_q;

    // Drive state: persists until a later 0, 1 or Z drive.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            drv <= 1'b0;
            oe  <= 1'b0;
        end else if (apply && evt.op == OP_DRV) begin
            case (evt.val)
                VAL_0:   begin drv <= 1'b0; oe <= 1'b1; end
                VAL_1:   begin drv <= 1'b1; oe <= 1'b1; end
                VAL_Z:   begin drv <= 1'b0; oe <= 1'b0; end
                default: begin drv <= drv;  oe <= oe;   end
            endcase
        end
    end

    // Measure state: lives for exactly one cycle after its step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            meas_on <= 1'b0;
            exp_q   <= VAL_X;
        end else begin
            meas_on <= apply && (evt.op == OP_MEAS);
            exp_q   <= evt.val;
        end
    end

    assign cmp_en = meas_on && !exp_q[1];
    assign miss   = cmp_en && (pin_in != exp_q[0]);

    p_meas_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> !meas_on);
    p_drive_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !clr) |=> ($stable(drv) && $stable(oe)));
    p_z_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && !clr && evt.op == OP_DRV && evt.val == VAL_Z) |=> !oe);
endmodule

// File: rtl/pattern_step_seq.sv
// Stored-pattern step sequencer: consumes one step per cycle from the built-in
// program or the loader port, applies drives, compares measures, and reports
// done, illegal-step error and first-failure index.
// Assumes start is a pulse; the source choice is captured when start is taken.
module pattern_step_seq
    import pss_pkg::*;
#(
    parameter int NTERM  = 4,
    parameter int LOOP_N = 1024,
    parameter int IDXW   = 16,
    parameter int A1_T   = 0,
    parameter int B_T    = 1,
    parameter int C_T    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   start,
    input  logic                   src_ld,
    input  logic                   ld_valid,
    input  logic [NTERM*4-1:0]     ld_step,
    input  logic                   ld_last,
    input  logic [NTERM-1:0]       term_in,
    output logic [NTERM-1:0]       term_drv,
    output logic [NTERM-1:0]       term_oe,
    output logic [NTERM-1:0]       meas_on,
    output logic [NTERM-1:0]       cmp_en,
    output logic                   busy,
    output logic                   done,
    output logic                   err,
    output logic                   fail,
    output logic [IDXW-1:0]        fail_step
);
    localparam int SW = NTERM * EVT_W;

    logic             running, fin, src_q;
    logic [IDXW-1:0]  idx, cur_idx;
    logic [SW-1:0]    prog_step, step;
    logic             prog_last, step_last, step_vld, step_bad, apply, start_ok;
    logic [NTERM-1:0] is_drv, is_meas, miss;

    pss_prog #(
        .NTERM(NTERM), .LOOP_N(LOOP_N), .IDXW(IDXW),
        .A1_T(A1_T), .B_T(B_T), .C_T(C_T)
    ) u_prog (
        .idx  (idx),
        .step (prog_step),
        .last (prog_last)
    );

    assign start_ok  = start && cfg_en && !running && !fin;
    assign step      = src_q ? ld_step : prog_step;
    assign step_last = src_q ? ld_last : prog_last;
    assign step_vld  = running && cfg_en && (src_q ? ld_valid : 1'b1);
    assign step_bad  = (|is_drv) && (|is_meas);
    assign apply     = step_vld && !step_bad;

    for (genvar i = 0; i < NTERM; i++) begin : g_lane
        evt_t ev;
        assign ev         = evt_t'(step[i*EVT_W +: EVT_W]);
        assign is_drv[i]  = (ev.op == OP_DRV);
        assign is_meas[i] = (ev.op == OP_MEAS);
        pss_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start_ok),
            .apply   (apply),
            .evt     (ev),
            .pin_in  (term_in[i]),
            .drv     (term_drv[i]),
            .oe      (term_oe[i]),
            .meas_on (meas_on[i]),
            .cmp_en  (cmp_en[i]),
            .miss    (miss[i])
        );
    end

    // Run control, step index and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            fin       <= 1'b0;
            src_q     <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
            fail      <= 1'b0;
            idx       <= '0;
            cur_idx   <= '0;
            fail_step <= '0;
        end else if (start_ok) begin
            running   <= 1'b1;
            fin       <= 1'b0;
            src_q     <= src_ld;
            done      <= 1'b0;
            err       <= 1'b0;
            fail      <= 1'b0;
            idx       <= '0;
            fail_step <= '0;
        end else begin
            if (step_vld && step_bad) begin
                err     <= 1'b1;
                running <= 1'b0;
            end else if (apply) begin
                idx     <= idx + 1'b1;
                cur_idx <= idx;
                if (step_last) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
            if (fin) begin
                fin  <= 1'b0;
                done <= 1'b1;
            end
            if ((|miss) && !fail) begin
                fail      <= 1'b1;
                fail_step <= cur_idx;
            end
        end
    end

    assign busy = running;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_ok) |=> ($stable(term_oe) && $stable(term_drv)));
    p_bad_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_bad && !start_ok) |=> (err && !busy && !done));
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start_ok) |=> (fail && $stable(fail_step)));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !busy);
endmodule

// File: tb/tb_pattern_step_seq.sv
// Scoreboard bench: driver tasks push expected terminal states per cycle,
// a monitor pops and compares them at the falling edge.
module tb_pattern_step_seq;
    localparam int CLK_P  = 10;
    localparam int NTERM  = 4;
    localparam int LOOP_N = 4;
    localparam int IDXW   = 8;
    localparam int PLEN   = 4 * LOOP_N + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, start = 1'b0, src_ld = 1'b0, ld_valid = 1'b0, ld_last = 1'b0;
    logic [NTERM*4-1:0] ld_step = '0;
    logic [NTERM-1:0]   term_in = '0;
    logic [NTERM-1:0]   term_drv, term_oe, meas_on, cmp_en;
    logic busy, done, err, fail;
    logic [IDXW-1:0] fail_step;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int         due;
        logic [3:0] drv, oe, meas, cmp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    pattern_step_seq #(.NTERM(NTERM), .LOOP_N(LOOP_N), .IDXW(IDXW)) dut (
        .clk, .rst_n, .cfg_en, .start, .src_ld, .ld_valid, .ld_step, .ld_last,
        .term_in, .term_drv, .term_oe, .meas_on, .cmp_en,
        .busy, .done, .err, .fail, .fail_step
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic logic [3:0] ev(input logic [1:0] op, input logic [1:0] val);
        return {op, val};
    endfunction

    task automatic push(input int due, input logic [3:0] d, input logic [3:0] o,
                        input logic [3:0] m, input logic [3:0] c, input string tag);
        exp_t e;
        e.due = due; e.drv = d; e.oe = o; e.meas = m; e.cmp = c; e.tag = tag;
        sb.push_back(e);
    endtask

    // Present one loader cycle and push the state expected after the next edge.
    task automatic put(input logic [15:0] s, input bit lst, input bit vld, input bit cfg,
                       input logic [3:0] d, input logic [3:0] o, input logic [3:0] m,
                       input logic [3:0] c, input string tag);
        @(negedge clk);
        start = 1'b0; cfg_en = cfg; ld_valid = vld; ld_step = s; ld_last = lst;
        push(cyc + 1, d, o, m, c, tag);
    endtask

    task automatic start_run(input bit ld, output int base);
        @(negedge clk);
        cfg_en = 1'b1; src_ld = ld; start = 1'b1; ld_valid = 1'b0; ld_last = 1'b0;
        base = cyc;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: compare scoreboard entries in their due cycle.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.due == cyc, {e.tag, " timing"}, cyc, e.due);
                chk(term_drv == e.drv, {e.tag, " drv"}, term_drv, e.drv);
                chk(term_oe == e.oe, {e.tag, " oe"}, term_oe, e.oe);
                chk(meas_on == e.meas, {e.tag, " meas_on"}, meas_on, e.meas);
                chk(cmp_en == e.cmp, {e.tag, " cmp_en"}, cmp_en, e.cmp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(term_oe == 0 && term_drv == 0, "R1 terminals released", {term_oe, term_drv}, 0);
        chk(meas_on == 0, "R1 no measure", meas_on, 0);
        chk({busy, done, fail, err} == 0, "R1 flags clear", {busy, done, fail, err}, 0);

        // R2: start without configuration is ignored
        @(negedge clk); cfg_en = 1'b0; src_ld = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R2 start ignored without cfg_en", busy, 0);

        // Loader run: R3 R4 R5 R6 R8 R9 R11
        term_in = 4'b1000;
        start_run(1'b1, base);
        put({ev(2'b00, 2'b00), ev(2'b01, 2'b01), ev(2'b01, 2'b00), ev(2'b01, 2'b01)}, 0, 1, 1,
            4'b0101, 4'b0111, 4'b0000, 4'b0000, "R3 drive 0/1");
        put({ev(2'b00, 2'b00), ev(2'b01, 2'b10), ev(2'b00, 2'b00), ev(2'b01, 2'b11)}, 0, 1, 1,
            4'b0001, 4'b0011, 4'b0000, 4'b0000, "R3 Z release, R4 X drive holds");
        put(16'h0000, 0, 0, 1, 4'b0001, 4'b0011, 4'b0000, 4'b0000, "R11 gap holds");
        put({ev(2'b10, 2'b01), ev(2'b10, 2'b11), ev(2'b00, 2'b00), ev(2'b00, 2'b00)}, 0, 1, 1,
            4'b0001, 4'b0011, 4'b1100, 4'b1000, "R6 masked X, R5 measure pass");
        put(16'h0000, 0, 1, 1, 4'b0001, 4'b0011, 4'b0000, 4'b0000, "R5 measure lasts one step");
        @(negedge clk);
        chk(fail == 1'b0, "R6 masked/pass measures do not fail", fail, 0);
        start = 1'b0; cfg_en = 1'b1; ld_valid = 1'b1; ld_last = 1'b0;
        ld_step = {ev(2'b10, 2'b00), ev(2'b10, 2'b10), ev(2'b00, 2'b00), ev(2'b00, 2'b00)};
        push(cyc + 1, 4'b0001, 4'b0011, 4'b1100, 4'b1000, "R8 mismatch step 4");
        put({ev(2'b10, 2'b00), ev(2'b00, 2'b00), ev(2'b00, 2'b00), ev(2'b00, 2'b00)}, 1, 1, 1,
            4'b0001, 4'b0011, 4'b1000, 4'b1000, "R8 second mismatch");
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
        chk(fail == 1'b1, "R8 fail latched", fail, 1);
        chk(fail_step == 8'd4, "R8 first failing index (gap not counted, R11)", fail_step, 4);
        chk(done == 1'b0, "R9 done not before last compare", done, 0);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R9 done after last step", {done, busy}, 2'b10);
        chk(fail_step == 8'd4, "R8 later mismatch ignored", fail_step, 4);

        // R2: steps paused while cfg_en low
        start_run(1'b1, base);
        put({12'h000, ev(2'b01, 2'b01)}, 0, 1, 1, 4'b0001, 4'b0001, 4'b0000, 4'b0000, "R2 run step");
        put({12'h000, ev(2'b01, 2'b00)}, 0, 1, 0, 4'b0001, 4'b0001, 4'b0000, 4'b0000, "R2 paused step");
        put({12'h000, ev(2'b01, 2'b00)}, 1, 1, 1, 4'b0000, 4'b0001, 4'b0000, 4'b0000, "R2 resumed step");
        @(negedge clk);
        ld_valid = 1'b0; ld_last = 1'b0;
        @(negedge clk);
        chk(done == 1'b1 && fail == 1'b0, "R9 done after paused run", {done, fail}, 2'b10);

        // R7: mixed step halts
        start_run(1'b1, base);
        put({8'h00, ev(2'b10, 2'b01), ev(2'b01, 2'b01)}, 0, 1, 1,
            4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 mixed step not applied");
        put({12'h000, ev(2'b01, 2'b01)}, 0, 1, 1,
            4'b0000, 4'b0000, 4'b0000, 4'b0000, "R7 no step after halt");
        chk(err == 1'b1 && busy == 1'b0, "R7 err and halt", {err, busy}, 2'b10);
        chk(done == 1'b0, "R7 no done on error", done, 0);
        ld_valid = 1'b0;

        // R10: built-in program, passing responses (b=1, c=0)
        term_in = 4'b0010;
        start_run(1'b0, base);
        for (int i = 0; i < PLEN; i++) begin
            if (i < 4 * LOOP_N) begin
                push(base + 2 + i, ((i % 4) == 1) ? 4'b0001 : 4'b0000, 4'b0001,
                     ((i % 4) == 3) ? 4'b0100 : 4'b0000, ((i % 4) == 3) ? 4'b0100 : 4'b0000,
                     "R10 loop step");
            end else if (i == 4 * LOOP_N) begin
                push(base + 2 + i, 4'b0000, 4'b0001, 4'b0000, 4'b0000, "R10 final drive");
            end else begin
                push(base + 2 + i, 4'b0000, 4'b0001, 4'b0010, 4'b0010, "R10 flag measure");
            end
        end
        @(negedge clk); start = 1'b0;
        wait_cyc(base + PLEN + 1);
        chk(done == 1'b0, "R9 done not early in program", done, 0);
        wait_cyc(base + PLEN + 2);
        chk(done == 1'b1 && busy == 1'b0 && fail == 1'b0, "R10 program passes, R9 done",
            {done, busy, fail}, 3'b100);

        // R10/R8: program with a stuck-high c response
        term_in = 4'b0110;
        start_run(1'b0, base);
        @(negedge clk); start = 1'b0;
        wait_cyc(base + 5);
        chk(fail == 1'b0, "R8 no fail before compare edge", fail, 0);
        wait_cyc(base + 6);
        chk(fail == 1'b1 && fail_step == 8'd3, "R8 program first failure index", fail_step, 3);
        wait_cyc(base + PLEN + 2);
        chk(done == 1'b1 && fail_step == 8'd3, "R10 failing program completes", fail_step, 3);

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule